// File: doc/BRIEF.md
# Flash initialization command sequencer

Before a serial flash can serve execute-in-place traffic, many parts need a few single-byte commands first, such as a write enable or a sector unprotect. This block sends that preamble. A configuration word holds up to three opcodes, how many of them to send, the bus width, and whether to poll the flash status afterwards. A start strobe captures the word and runs the sequence. Each opcode goes out in its own chip-select frame on one, two or four data lanes.

When the status check is enabled, the block then sends the read-status opcode on a single lane. It keeps clocking status bytes in the same frame until the busy bit reads zero. Completion is signalled by a one-cycle done pulse. A reserved lane setting is rejected at once with an error pulse. The serial clock runs at half the system clock. Data changes while the serial clock is low, and the flash samples it on the rising edge.

Top module: `flash_init_seq`

## Requirements
- R1: The configuration word is laid out as follows: bits 7:0, 15:8 and 23:16 hold opcodes one, two and three; bits 25:24 are the lane code; bits 27:26 are the opcode count; bit 28 is the status-check enable. The opcode count (0 to 3) sets how many opcode frames are sent.
- R2: Opcodes are sent in the order one, two, three, each in its own chip-select frame holding exactly that byte.
- R3: Lane code 00 sends 8 serial clocks per opcode, code 01 sends 4, and code 10 sends 2.
- R4: Lane code 11 sends nothing and asserts err_o and done_o together, one cycle after start. busy_o stays low.
- R5: When the count is 0 and the status check is off, done_o pulses one cycle after start, and chip select is never asserted.
- R6: Between frames, chip select stays high for at least 2 system clocks. The serial clock is low whenever chip select is high.
- R7: With the status check on, the last frame sends opcode 0x05 on lane 0 and then reads status bytes MSB first from miso_i. It repeats the read until bit 0 (busy) is 0, then ends the frame and pulses done_o.
- R8: While a sequence runs, busy_o is high and start_i is ignored. The configuration is captured only on the accepted start.
- R9: In reset, chip select is high, the serial clock is low, all output enables are 0, and busy_o, done_o and err_o are 0.
- R10: Multi-bit beats put the more significant bit on the higher lane. Single lane uses sdo_o[0], dual uses sdo_o[1:0], and quad uses sdo_o[3:0]. The output enables are set only on the lanes in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 29 | Configuration word (opcodes, lane code, count, status check) |
| start_i | input | 1 | Start strobe, accepted when idle |
| miso_i | input | 1 | Serial data from flash, used by the status poll |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, idle low |
| sdo_o | output | 4 | Serial data lanes to flash |
| sdo_oe_o | output | 4 | Per-lane output enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse, reserved lane code |

## Verification
The bench goes after the edges of the count field. A count of zero must produce no frames, and a count of three must produce three frames in order. An off-by-one in the count would drop or add a frame, and a swapped field would show up as a wrong byte in a frame. It uses asymmetric opcodes on dual and quad lanes, so a lane mapping reversed inside a beat captures as a different byte, and a wrong beat count shows as a serial clock count other than 8, 4 or 2. Status polls of zero to three busy bytes check that the poll stops exactly when the busy bit reads zero. The bench also drives a garbage configuration and a second start during a run; a design that samples the word late or restarts would send the wrong opcodes.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int OP_W  = 8;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    LANE_X1  = 2'b00,
    LANE_X2  = 2'b01,
    LANE_X4  = 2'b10,
    LANE_RSV = 2'b11
  } lane_e;

  // msb-first packing gives chk at 28, cnt 27:26, lane 25:24
  typedef struct packed {
    logic            chk;
    logic [1:0]      cnt;
    lane_e           lane;
    logic [OP_W-1:0] op3;
    logic [OP_W-1:0] op2;
    logic [OP_W-1:0] op1;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_XFER,
    S_GAP,
    S_POLL_OP,
    S_POLL_RD
  } st_e;
endpackage

// File: rtl/fis_shifter.sv
module fis_shifter import fis_pkg::*; #(
  parameter int DW = OP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] byte_i,
  input  lane_e         lane_i,
  input  logic          rx_i,
  input  logic          miso_i,
  output logic          sck_o,
  output logic [LANES-1:0] sdo_o,
  output logic [LANES-1:0] oe_o,
  output logic          rx_last_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BEATS_X1 = CW'(DW);
  localparam logic [CW-1:0] BEATS_X2 = CW'(DW / 2);
  localparam logic [CW-1:0] BEATS_X4 = CW'(DW / 4);

  logic          active_q, phase_q, sck_q, done_q, rx_q, rx_last_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;
  lane_e         lane_q;
  logic [CW-1:0] beats;

  always_comb begin
    unique case (lane_i)
      LANE_X2: beats = BEATS_X2;
      LANE_X4: beats = BEATS_X4;
      default: beats = BEATS_X1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      phase_q   <= 1'b0;
      sck_q     <= 1'b0;
      done_q    <= 1'b0;
      rx_q      <= 1'b0;
      rx_last_q <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      lane_q    <= LANE_X1;
    end else begin
      done_q <= 1'b0;
      if (ld_i) begin
        sh_q     <= byte_i;
        lane_q   <= lane_i;
        rx_q     <= rx_i;
        cnt_q    <= beats;
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        sck_q    <= 1'b0;
      end else if (active_q) begin
        if (!phase_q) begin
          sck_q   <= 1'b1;
          phase_q <= 1'b1;
          if (rx_q) rx_last_q <= miso_i;
        end else begin
          sck_q   <= 1'b0;
          phase_q <= 1'b0;
          unique case (lane_q)
            LANE_X2: sh_q <= sh_q << 2;
            LANE_X4: sh_q <= sh_q << 4;
            default: sh_q <= sh_q << 1;
          endcase
          if (cnt_q == CW'(1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    sdo_o = '0;
    oe_o  = '0;
    if (active_q && !rx_q) begin
      unique case (lane_q)
        LANE_X2: begin sdo_o[1:0] = sh_q[DW-1 -: 2]; oe_o = 4'b0011; end
        LANE_X4: begin sdo_o      = sh_q[DW-1 -: 4]; oe_o = 4'b1111; end
        default: begin sdo_o[0]   = sh_q[DW-1];      oe_o = 4'b0001; end
      endcase
    end
  end

  assign sck_o     = sck_q;
  assign done_o    = done_q;
  assign rx_last_o = rx_last_q; // status bits arrive msb first, so busy bit 0 is last

  p_ld_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !active_q);
  p_done_sck_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !sck_q);
endmodule

// File: rtl/fis_ctrl.sv
module fis_ctrl import fis_pkg::*; #(
  parameter int          GAP_CYC = 2,
  parameter logic [OP_W-1:0] POLL_OP = 8'h05
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  cfg_t            cfg_i,
  input  logic            sh_done_i,
  input  logic            sh_last_i,
  output logic            ld_o,
  output logic [OP_W-1:0] ld_byte_o,
  output lane_e           ld_lane_o,
  output logic            ld_rx_o,
  output logic            cs_no,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int GW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [GW-1:0] GAP_LD = GW'(GAP_CYC - 1);

  st_e             state_q;
  cfg_t            cfg_q;
  logic [1:0]      idx_q;
  logic [GW-1:0]   gap_q;
  logic            cs_n_q, busy_q, done_q, err_q, ld_q, ld_rx_q;
  logic [OP_W-1:0] ld_byte_q, cmd_sel;
  lane_e           ld_lane_q;
  logic            more_work;

  always_comb begin
    unique case (idx_q)
      2'd0:    cmd_sel = cfg_q.op1;
      2'd1:    cmd_sel = cfg_q.op2;
      default: cmd_sel = cfg_q.op3;
    endcase
  end

  assign more_work = (idx_q < cfg_q.cnt) || cfg_q.chk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cfg_q     <= '0;
      idx_q     <= '0;
      gap_q     <= '0;
      cs_n_q    <= 1'b1;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ld_q      <= 1'b0;
      ld_rx_q   <= 1'b0;
      ld_byte_q <= '0;
      ld_lane_q <= LANE_X1;
    end else begin
      ld_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cfg_q <= cfg_i;
          idx_q <= '0;
          if (cfg_i.lane == LANE_RSV) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (cfg_i.cnt == 2'd0 && !cfg_i.chk) begin
            done_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          cs_n_q  <= 1'b0;
          ld_q    <= 1'b1;
          ld_rx_q <= 1'b0;
          if (idx_q < cfg_q.cnt) begin
            ld_byte_q <= cmd_sel;
            ld_lane_q <= cfg_q.lane;
            idx_q     <= idx_q + 2'd1;
            state_q   <= S_XFER;
          end else begin
            ld_byte_q <= POLL_OP;
            ld_lane_q <= LANE_X1;
            state_q   <= S_POLL_OP;
          end
        end
        S_XFER: if (sh_done_i) begin
          cs_n_q <= 1'b1;
          if (more_work) begin
            gap_q   <= GAP_LD;
            state_q <= S_GAP;
          end else begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_GAP: begin
          if (gap_q == '0) state_q <= S_ISSUE;
          else             gap_q   <= gap_q - GW'(1);
        end
        S_POLL_OP: if (sh_done_i) begin
          ld_q      <= 1'b1;
          ld_rx_q   <= 1'b1;
          ld_lane_q <= LANE_X1;
          state_q   <= S_POLL_RD;
        end
        S_POLL_RD: if (sh_done_i) begin
          if (sh_last_i) begin
            ld_q <= 1'b1; // still busy: clock another status byte
          end else begin
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ld_o      = ld_q;
  assign ld_byte_o = ld_byte_q;
  assign ld_lane_o = ld_lane_q;
  assign ld_rx_o   = ld_rx_q;
  assign cs_no     = cs_n_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  p_cs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_q) |=> cs_n_q);
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(cfg_q));
  p_ld_framed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_q |-> !cs_n_q);
endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq import fis_pkg::*; #(
  parameter int GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             start_i,
  input  logic             miso_i,
  output logic             cs_no,
  output logic             sck_o,
  output logic [LANES-1:0] sdo_o,
  output logic [LANES-1:0] sdo_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic            ld, ld_rx, sh_done, sh_last;
  logic [OP_W-1:0] ld_byte;
  lane_e           ld_lane;

  fis_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cfg_i     (cfg_t'(cfg_i)),
    .sh_done_i (sh_done),
    .sh_last_i (sh_last),
    .ld_o      (ld),
    .ld_byte_o (ld_byte),
    .ld_lane_o (ld_lane),
    .ld_rx_o   (ld_rx),
    .cs_no     (cs_no),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  fis_shifter #(.DW(OP_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld),
    .byte_i    (ld_byte),
    .lane_i    (ld_lane),
    .rx_i      (ld_rx),
    .miso_i    (miso_i),
    .sck_o     (sck_o),
    .sdo_o     (sdo_o),
    .oe_o      (sdo_oe_o),
    .rx_last_o (sh_last),
    .done_o    (sh_done)
  );

  p_sck_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cs_no));
  p_err_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_drive_framed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o != '0) |-> !cs_no);
endmodule

// File: tb/flash_init_seq_tb.sv
module flash_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {poll busy bytes, config word}
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0, 32'h0400_00A5},
    {4'd0, 32'h0900_C35A},
    {4'd0, 32'h0E96_3CE1},
    {4'd0, 32'h0C01_80FF},
    {4'd3, 32'h1011_2233},
    {4'd0, 32'h1A00_0698},
    {4'd2, 32'h1500_00B7},
    {4'd1, 32'h1D7E_8124}
  };

  logic clk, rst_n, start, miso;
  logic [31:0] cfg_drv;
  logic cs_n, sck, busy, done, err;
  logic [3:0] sdo, oe;

  int checks = 0, fails = 0;
  bit fin = 0;

  // flash model state
  logic [7:0] cap, stat_byte;
  int nbits, frames, nlog, stat_bit, busy_left, status_reads;
  bit in_status;
  logic [7:0] log_b [16];
  int log_w [16];
  int fr_sck [16];
  int hi_run, min_gap, sck_bad;
  bit seen_low;

  flash_init_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg_drv[28:0]), .start_i(start),
    .miso_i(miso), .cs_no(cs_n), .sck_o(sck), .sdo_o(sdo), .sdo_oe_o(oe),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge cs_n) begin
    nbits = 0; cap = 0; in_status = 0;
    if (frames < 16) fr_sck[frames] = 0;
    frames++;
  end

  always @(posedge sck) if (!cs_n) begin
    if (frames > 0 && frames <= 16) fr_sck[frames-1]++;
    if (!in_status && oe != 4'b0000) begin
      int w;
      w = 0;
      case (oe)
        4'b0001: begin cap = {cap[6:0], sdo[0]};   w = 1; end
        4'b0011: begin cap = {cap[5:0], sdo[1:0]}; w = 2; end
        4'b1111: begin cap = {cap[3:0], sdo};      w = 4; end
        default: w = 8;
      endcase
      nbits += w;
      if (nbits >= 8) begin
        if (nlog < 16) begin log_b[nlog] = cap; log_w[nlog] = w; end
        nlog++;
        nbits = 0;
        if (cap == 8'h05 && w == 1) begin
          in_status = 1; stat_bit = 0;
          stat_byte = (busy_left > 0) ? 8'h81 : 8'h80;
        end
      end
    end
  end

  always @(negedge sck) if (!cs_n && in_status) begin
    miso = stat_byte[7-stat_bit];
    stat_bit++;
    if (stat_bit == 8) begin
      stat_bit = 0;
      status_reads++;
      busy_left--;
      stat_byte = (busy_left > 0) ? 8'h81 : 8'h80;
    end
  end

  always @(negedge clk) begin
    if (cs_n && sck) sck_bad++;
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0 && seen_low && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) seen_low = 1;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_model(input int polls);
    frames = 0; nlog = 0; busy_left = polls; status_reads = 0;
    min_gap = 1000; seen_low = 0; hi_run = 0; sck_bad = 0; in_status = 0;
  endtask

  task automatic run_seq(input logic [31:0] w, input int polls);
    int cnt, lane, wd, n;
    bit chk_en, got_busy;
    logic [7:0] ops [3];
    cnt = int'(w[27:26]); lane = int'(w[25:24]); chk_en = w[28];
    wd = (lane == 0) ? 1 : (lane == 1) ? 2 : 4;
    ops[0] = w[7:0]; ops[1] = w[15:8]; ops[2] = w[23:16];
    clear_model(polls);
    @(negedge clk); cfg_drv = w; start = 1;
    @(negedge clk); start = 0; cfg_drv = ~w;
    got_busy = busy;
    @(negedge clk); cfg_drv = 32'h0F00_0000 | ~w; start = 1; // ignored restart
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(got_busy, "R8 busy after start", int'(got_busy), 1);
    chk(done, "R7 done reached", int'(done), 1);
    chk(!err, "R4 no error on valid lane", int'(err), 0);
    repeat (3) @(negedge clk);
    chk(frames == cnt + int'(chk_en), "R1 frame count", frames, cnt + int'(chk_en));
    for (int i = 0; i < cnt; i++) begin
      chk(log_b[i] == ops[i], "R2 opcode order/value (R10 lanes, R8 capture)", int'(log_b[i]), int'(ops[i]));
      chk(log_w[i] == wd, "R3 lane width", log_w[i], wd);
      chk(fr_sck[i] == 8 / wd, "R3 serial clocks per opcode", fr_sck[i], 8 / wd);
    end
    if (chk_en) begin
      chk(log_b[cnt] == 8'h05, "R7 poll opcode", int'(log_b[cnt]), 5);
      chk(log_w[cnt] == 1, "R7 poll single lane", log_w[cnt], 1);
      chk(status_reads == polls + 1, "R7 status bytes read", status_reads, polls + 1);
      chk(fr_sck[cnt] == 8 * (polls + 2), "R7 poll frame clocks", fr_sck[cnt], 8 * (polls + 2));
    end
    if (frames > 1) chk(min_gap >= 2, "R6 chip select gap", min_gap, 2);
    chk(sck_bad == 0, "R6 sck low while deselected", sck_bad, 0);
    chk(!busy, "R8 busy cleared", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; cfg_drv = '0; miso = 0;
    clear_model(0);
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R9 reset cs", int'(cs_n), 1);
    chk(sck === 1'b0, "R9 reset sck", int'(sck), 0);
    chk(oe === 4'b0000, "R9 reset oe", int'(oe), 0);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R9 reset flags",
        int'({busy, done, err}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) run_seq(VEC[k][31:0], int'(VEC[k][35:32]));

    // R5: all-zero config finishes next cycle, no frame
    clear_model(0);
    @(negedge clk); cfg_drv = 32'h0000_0000; start = 1;
    @(negedge clk); start = 0;
    chk(done === 1'b1, "R5 done one cycle after start", int'(done), 1);
    chk(busy === 1'b0, "R5 busy stays low", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(frames == 0, "R5 no chip select", frames, 0);

    // R4: reserved lane code
    clear_model(0);
    @(negedge clk); cfg_drv = 32'h1F11_2233; start = 1;
    @(negedge clk); start = 0;
    chk(done === 1'b1 && err === 1'b1, "R4 done with error", int'({done, err}), 3);
    chk(busy === 1'b0, "R4 busy stays low", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(frames == 0, "R4 no frame sent", frames, 0);
    chk(err === 1'b0, "R4 error is a pulse", int'(err), 0);

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule